// File: doc/BRIEF.md
# Delayed Write Request Parity Handler

This block is the target-side front end of a bus bridge that accepts write requests for delayed completion. It watches an initiator's address phase and first data phase. It checks the even parity of the data word, and then picks one of two responses. The usual response captures the whole request into a delayed transaction queue and answers with a target retry. The initiator comes back later for completion. When the data parity is bad and parity error response is enabled, the block instead accepts the data word with TRDY# and does not queue the request. It disconnects with STOP# if the initiator wanted more than one data phase, and it pulses PERR# two cycles after the transfer.

A sticky detected-parity-error flag records every bad data word, whatever the enable setting, and a write-one-to-clear strobe clears it. When the queue reports full, the block still answers with a retry but writes nothing into the queue.

The controller has four states. ST_IDLE leaves the bus alone; FRAME# low moves it to ST_WAIT_DATA and captures address, command and address parity. ST_WAIT_DATA drives DEVSEL# and waits for IRDY#; IRDY# low captures data, byte enables, data parity, the error and burst flags, and moves to ST_RESPOND. ST_RESPOND drives the one-cycle answer; it returns to ST_IDLE if FRAME# is already high, otherwise it moves to ST_HOLD_STOP. ST_HOLD_STOP keeps STOP# and DEVSEL# low until FRAME# goes high, then returns to ST_IDLE.

Top module: `dwr_target`

## Requirements
- R1: During and right after reset, devsel_n, trdy_n, stop_n and perr_n are high, q_wr is low and dpe_flag is low.
- R2: In the cycle after frame_n is sampled low in idle, devsel_n goes low. It stays low until the block returns to idle, and trdy_n or stop_n are low only while devsel_n is low.
- R3: When the data parity is good, the cycle after irdy_n is first sampled low is a retry: stop_n low, trdy_n high. In that same single cycle, q_wr pulses with the captured address, command (C/BE lines of the address phase), address parity, data, active-high byte enables (inverse of C/BE lines in the data phase) and data parity.
- R4: A data parity error means an odd number of ones across the data word, the active-low C/BE lines and the parity bit, all sampled together in the data phase.
- R5: When a parity error occurs and per_en is high, the response cycle has trdy_n low and q_wr stays low. If frame_n was high in the data phase, stop_n stays high.
- R6: When a parity error occurs, per_en is high and frame_n is still low in the data phase (a burst), the response cycle has both trdy_n and stop_n low.
- R7: perr_n is low for exactly one cycle, two cycles after a response cycle that accepted data with trdy_n. It is never low otherwise.
- R8: When a parity error occurs and per_en is low, the response is a retry with a q_wr pulse, as for good data, and perr_n stays high.
- R9: dpe_flag goes high in the cycle after the response to a data word with a parity error, whether per_en is high or low, and stays high.
- R10: stat_clr high at a clock edge clears dpe_flag. A parity error set at the same edge takes priority.
- R11: When q_full is high during the response cycle, q_wr stays low and the response is still a plain retry.
- R12: After a response with stop_n low while frame_n is still low, stop_n and devsel_n stay low until frame_n is sampled high. At that point all handshake outputs go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | DW | Address / data lines |
| cbe_n | input | BEW | Command / byte-enable lines, active low |
| par | input | 1 | Even parity for ad and cbe_n |
| per_en | input | 1 | Parity error response enable |
| q_full | input | 1 | Delayed transaction queue is full |
| stat_clr | input | 1 | Write-one-to-clear strobe for dpe_flag |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| perr_n | output | 1 | Data parity error report, active low |
| q_wr | output | 1 | Queue write strobe |
| q_addr | output | DW | Captured address |
| q_cmd | output | BEW | Captured command |
| q_apar | output | 1 | Captured address parity |
| q_data | output | DW | Captured data word |
| q_be | output | BEW | Captured byte enables, active high |
| q_dpar | output | 1 | Captured data parity |
| dpe_flag | output | 1 | Sticky detected-parity-error flag |

## Verification
The bound assertions check several rules on every cycle: that an accepted word never produces a queue write, that a queue write only comes with a retry and lasts one cycle, that a full queue blocks the strobe, that PERR# follows an accepting TRDY# by exactly two cycles in both directions, and that the handshake outputs appear only under DEVSEL#. Only the bench's scenarios can show other behaviours. Those are the choice between retry and accept under each mix of parity, enable and burst, the content of the captured fields, the parity rule with the error placed on a data, C/BE or parity bit, the flag's priority over a clear in the same cycle, and the way STOP# is held until FRAME# rises.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_DATA = 2'd1,
        ST_RESPOND   = 2'd2,
        ST_HOLD_STOP = 2'd3
    } dwr_state_t;

endpackage

// File: rtl/dwr_parity_chk.sv
module dwr_parity_chk #(
    parameter int W = 37
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    always_comb begin
        odd = 1'b0;
        for (int i = 0; i < W; i++) begin
            odd = odd ^ bits[i];
        end
    end
endmodule

// File: rtl/dwr_perr_pipe.sv
module dwr_perr_pipe (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic perr_n
);
    logic stage1;
    logic stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= fire;
            stage2 <= stage1;
        end
    end

    assign perr_n = ~stage2;
endmodule

// File: rtl/dwr_sticky.sv
module dwr_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dwr_target.sv
module dwr_target
    import dwr_pkg::*;
#(
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_n,
    input  logic           irdy_n,
    input  logic [DW-1:0]  ad,
    input  logic [BEW-1:0] cbe_n,
    input  logic           par,
    input  logic           per_en,
    input  logic           q_full,
    input  logic           stat_clr,
    output logic           devsel_n,
    output logic           trdy_n,
    output logic           stop_n,
    output logic           perr_n,
    output logic           q_wr,
    output logic [DW-1:0]  q_addr,
    output logic [BEW-1:0] q_cmd,
    output logic           q_apar,
    output logic [DW-1:0]  q_data,
    output logic [BEW-1:0] q_be,
    output logic           q_dpar,
    output logic           dpe_flag
);
    localparam int PW = DW + BEW + 1;

    dwr_state_t     state;
    dwr_state_t     nstate;
    logic [DW-1:0]  addr_q;
    logic [BEW-1:0] cmd_q;
    logic           apar_q;
    logic [DW-1:0]  data_q;
    logic [BEW-1:0] be_n_q;
    logic           dpar_q;
    logic           err_q;
    logic           burst_q;
    logic           accept_q;
    logic           par_bad;
    logic           take_addr;
    logic           take_data;
    logic           in_resp;

    dwr_parity_chk #(.W(PW)) u_par (
        .bits ({ad, cbe_n, par}),
        .odd  (par_bad)
    );

    assign take_addr = (state == ST_IDLE) && !frame_n;
    assign take_data = (state == ST_WAIT_DATA) && !irdy_n;
    assign in_resp   = (state == ST_RESPOND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:      if (!frame_n) nstate = ST_WAIT_DATA;
            ST_WAIT_DATA: if (!irdy_n)  nstate = ST_RESPOND;
            ST_RESPOND:   nstate = frame_n ? ST_IDLE : ST_HOLD_STOP;
            ST_HOLD_STOP: if (frame_n)  nstate = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cmd_q    <= '0;
            apar_q   <= 1'b0;
            data_q   <= '0;
            be_n_q   <= '1;
            dpar_q   <= 1'b0;
            err_q    <= 1'b0;
            burst_q  <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            if (take_addr) begin
                addr_q <= ad;
                cmd_q  <= cbe_n;
                apar_q <= par;
            end
            if (take_data) begin
                data_q   <= ad;
                be_n_q   <= cbe_n;
                dpar_q   <= par;
                err_q    <= par_bad;
                burst_q  <= !frame_n;
                accept_q <= par_bad && per_en;
            end
        end
    end

    // handshake outputs
    always_comb begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
        q_wr     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT_DATA: devsel_n = 1'b0;
            ST_RESPOND: begin
                devsel_n = 1'b0;
                if (accept_q) begin
                    trdy_n = 1'b0;
                    stop_n = !burst_q;
                end else begin
                    stop_n = 1'b0;
                    q_wr   = !q_full;
                end
            end
            ST_HOLD_STOP: begin
                devsel_n = 1'b0;
                stop_n   = 1'b0;
            end
        endcase
    end

    assign q_addr = addr_q;
    assign q_cmd  = cmd_q;
    assign q_apar = apar_q;
    assign q_data = data_q;
    assign q_be   = ~be_n_q;
    assign q_dpar = dpar_q;

    dwr_perr_pipe u_perr (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (in_resp && accept_q),
        .perr_n (perr_n)
    );

    dwr_sticky u_dpe (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (in_resp && err_q),
        .clr   (stat_clr),
        .flag  (dpe_flag)
    );
endmodule

// File: rtl/dwr_target_sva.sv
module dwr_target_sva (
    input logic clk,
    input logic rst_n,
    input logic irdy_n,
    input logic q_full,
    input logic stat_clr,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic perr_n,
    input logic q_wr,
    input logic dpe_flag
);
    assert_accept_no_queue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !q_wr);

    assert_queue_with_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr |-> (!stop_n && trdy_n));

    assert_queue_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr |=> !q_wr);

    assert_full_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !q_wr);

    assert_perr_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n) |-> ##2 !perr_n);

    assert_perr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(!trdy_n, 2));

    assert_handshake_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n || !stop_n) |-> !devsel_n);

    assert_flag_set_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpe_flag) |-> $past(!trdy_n || !stop_n));

    assert_flag_clear_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dpe_flag) |-> $past(stat_clr));
endmodule

bind dwr_target dwr_target_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .irdy_n   (irdy_n),
    .q_full   (q_full),
    .stat_clr (stat_clr),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .perr_n   (perr_n),
    .q_wr     (q_wr),
    .dpe_flag (dpe_flag)
);

// File: tb/dwr_target_test.sv
module dwr_target_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '1;
    logic        par = 1'b0;
    logic        per_en = 1'b1;
    logic        q_full = 1'b0;
    logic        stat_clr = 1'b0;
    logic        devsel_n, trdy_n, stop_n, perr_n, q_wr, q_apar, q_dpar, dpe_flag;
    logic [31:0] q_addr, q_data;
    logic [3:0]  q_cmd, q_be;

    int checks = 0;
    int errors = 0;

    dwr_target uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .ad(ad), .cbe_n(cbe_n), .par(par), .per_en(per_en), .q_full(q_full),
        .stat_clr(stat_clr), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .perr_n(perr_n), .q_wr(q_wr), .q_addr(q_addr),
        .q_cmd(q_cmd), .q_apar(q_apar), .q_data(q_data), .q_be(q_be),
        .q_dpar(q_dpar), .dpe_flag(dpe_flag)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int  m_phase = 0;   // 0 bus free, 1 claimed, 2 answering, 3 holding stop
    int  cyc = 0;
    int  perr_due[$];
    bit  m_err, m_burst, m_acc, m_dpe;
    logic [31:0] m_addr, m_data;
    logic [3:0]  m_cmd, m_be;
    logic        m_apar, m_dpar;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
            m_dpe = 0;
            perr_due.delete();
        end else begin
            if (m_phase == 2 && m_err) m_dpe = 1;
            else if (stat_clr) m_dpe = 0;
            case (m_phase)
                0: if (!frame_n) begin
                    m_addr = ad; m_cmd = cbe_n; m_apar = par; m_phase = 1;
                end
                1: if (!irdy_n) begin
                    m_data = ad; m_be = ~cbe_n; m_dpar = par;
                    m_err = ($countones({ad, cbe_n, par}) % 2) == 1;
                    m_burst = !frame_n;
                    m_acc = m_err && per_en;
                    m_phase = 2;
                end
                2: begin
                    if (m_acc) perr_due.push_back(cyc + 2);
                    m_phase = frame_n ? 0 : 3;
                end
                default: if (frame_n) m_phase = 0;
            endcase
            cyc++;
        end
    end

    int n_q = 0, n_perr = 0, n_trdy = 0, n_stop = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_perr;
            bit e_trdy;
            bit e_stop;
            bit e_qwr;
            e_perr = (perr_due.size() > 0) && (perr_due[0] == cyc);
            if (e_perr) void'(perr_due.pop_front());
            e_trdy = (m_phase == 2) && m_acc;
            e_stop = ((m_phase == 2) && (!m_acc || m_burst)) || (m_phase == 3);
            e_qwr  = (m_phase == 2) && !m_acc && !q_full;
            check("R2", "devsel_n", devsel_n, !(m_phase != 0));
            check("R5", "trdy_n", trdy_n, !e_trdy);
            check(m_phase == 3 ? "R12" : (m_acc ? "R6" : "R3"), "stop_n", stop_n, !e_stop);
            check("R7", "perr_n", perr_n, !e_perr);
            check(q_full ? "R11" : "R3", "q_wr", q_wr, e_qwr);
            check("R9", "dpe_flag", dpe_flag, m_dpe);
            if (e_qwr) begin
                check("R3", "q_addr", q_addr, m_addr);
                check("R3", "q_cmd", q_cmd, m_cmd);
                check("R3", "q_apar", q_apar, m_apar);
                check("R3", "q_data", q_data, m_data);
                check("R3", "q_be", q_be, m_be);
                check("R3", "q_dpar", q_dpar, m_dpar);
            end
            if (q_wr) n_q++;
            if (!perr_n) n_perr++;
            if (!trdy_n) n_trdy++;
            if (!stop_n) n_stop++;
        end
    end

    function automatic logic even_par(input logic [35:0] v);
        return ($countones(v) % 2) == 1;
    endfunction

    task automatic run_txn(input string req, input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] be, input logic [31:0] dflip, input logic [3:0] bflip,
                           input bit pflip, input bit burst, input bit en, input bit full,
                           input int waits, input bit clr_resp,
                           input int exp_q, input int exp_perr, input int exp_trdy, input int exp_stop);
        n_q = 0; n_perr = 0; n_trdy = 0; n_stop = 0;
        @(posedge clk); #1;
        frame_n = 0; ad = a; cbe_n = 4'h7; par = even_par({a, 4'h7});
        per_en = en; q_full = full;
        for (int w = 0; w < waits; w++) begin
            @(posedge clk); #1;
            frame_n = 0; irdy_n = 1;
        end
        @(posedge clk); #1;
        irdy_n = 0; frame_n = !burst;
        ad = d ^ dflip; cbe_n = ~be ^ bflip; par = even_par({d, ~be}) ^ pflip;
        @(posedge clk); #1;
        stat_clr = clr_resp;
        @(posedge clk); #1;
        stat_clr = 0; frame_n = 1; irdy_n = burst ? 1'b0 : 1'b1;
        @(posedge clk); #1;
        irdy_n = 1;
        repeat (3) @(posedge clk);
        #2;
        check(req, "queue writes", n_q, exp_q);
        check(req, "perr cycles", n_perr, exp_perr);
        check(req, "trdy cycles", n_trdy, exp_trdy);
        check(req, "stop cycles", n_stop, exp_stop);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", "devsel_n in reset", devsel_n, 1);
        check("R1", "trdy_n in reset", trdy_n, 1);
        check("R1", "stop_n in reset", stop_n, 1);
        check("R1", "perr_n in reset", perr_n, 1);
        check("R1", "q_wr in reset", q_wr, 0);
        check("R1", "dpe_flag in reset", dpe_flag, 0);
        @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #2;
        check("R1", "devsel_n after reset", devsel_n, 1);
        check("R1", "dpe_flag after reset", dpe_flag, 0);

        // R3: good single-phase word is retried and queued
        run_txn("R3", 32'h1000_0040, 32'hDEAD_BEEF, 4'hF, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 1);
        // R12: good burst is retried, stop held until frame rises
        run_txn("R12", 32'h2000_0080, 32'h0123_4567, 4'h3, 0, 0, 0, 1, 1, 0, 1, 0, 1, 0, 0, 2);
        // R5 / R7: bad single word with enable set
        run_txn("R5", 32'h3000_0000, 32'hFFFF_0000, 4'hC, 0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 1, 0);
        check("R9", "flag after error", dpe_flag, 1);
        // R10: clear strobe
        @(posedge clk); #1; stat_clr = 1;
        @(posedge clk); #1; stat_clr = 0; #1;
        check("R10", "flag cleared", dpe_flag, 0);
        // R6: bad burst with enable set
        run_txn("R6", 32'h4000_0010, 32'hA5A5_A5A5, 4'hF, 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1, 2);
        // R8: bad word, enable clear, is queued and not reported, flag still set
        @(posedge clk); #1; stat_clr = 1;
        @(posedge clk); #1; stat_clr = 0;
        run_txn("R8", 32'h5000_0020, 32'h0000_00FF, 4'h1, 0, 0, 1, 0, 0, 0, 1, 0, 1, 0, 0, 1);
        check("R8", "flag with enable clear", dpe_flag, 1);
        // R10: set at the same edge as a clear wins
        @(posedge clk); #1; stat_clr = 1;
        @(posedge clk); #1; stat_clr = 0;
        run_txn("R10", 32'h5100_0000, 32'h1111_1111, 4'hF, 0, 0, 1, 0, 1, 0, 0, 1, 0, 1, 1, 0);
        check("R10", "set beats clear", dpe_flag, 1);
        // R11: queue full gives plain retry, no strobe
        run_txn("R11", 32'h6000_0000, 32'h7777_7777, 4'hF, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 1);
        // R4: error carried by a data bit
        run_txn("R4", 32'h7000_0000, 32'h8000_0001, 4'hF, 32'h0001_0000, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, 0);
        // R4: error carried by a byte-enable line
        run_txn("R4", 32'h7100_0000, 32'hFFFF_FFFF, 4'h6, 0, 4'h8, 0, 0, 1, 0, 0, 0, 0, 1, 1, 0);
        // R4: two flipped data bits keep parity even, treated as good
        run_txn("R4", 32'h7200_0000, 32'h0F0F_0F0F, 4'hF, 32'h0000_0003, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 1);
        // R2: initiator wait states before the data phase
        run_txn("R2", 32'h8000_0000, 32'h2468_ACE0, 4'hA, 0, 0, 0, 0, 1, 0, 3, 0, 1, 0, 0, 1);

        repeat (4) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule